// File: doc/BRIEF.md
# Multiplexed Transmit Line Scanner

This block is the transmit half of a multi-line serial multiplexer that software drives through one small register window. Software sets a per-line enable mask, turns on scanning and optionally the transmit interrupt. A round-robin scanner then walks the lines one per clock. When it lands on a line that is enabled and whose serializer is idle, it stops, raises a ready flag and publishes that line's number in the status word.

Software answers by writing one character to the shared data register. The character goes to whichever line is being reported, because the scanner, not software, chooses the target. Each line has a one-character serializer with no queue behind it. A global clear command resets the mask, the control bits, the scanner and any frame in flight. The clear stays visible in the status word for a fixed number of cycles.

Register window: address 0 is status and control, address 1 is the line enable mask, address 2 is the write-only data register, and address 3 reads as zero.

Top module: `txmux_scan`

## Requirements
- R1: After reset, status, mask and data addresses read 0, `tx_irq` is 0 and every `txd` bit is 1 (idle).
- R2: Mask register (address 1) bit n enables line n. It reads back what was written in its low NLINES bits. A line whose bit is 0 is never reported.
- R3: The status word (address 0) shows the ready flag at bit 7 and the reported line number in the field starting at bit 8. The field reads 0 while the ready flag is clear.
- R4: A write to address 2 while ready loads `wdata[7:0]` into the reported line. That line sends a frame of one start bit (0), eight data bits LSB first and one stop bit (1), each lasting BIT_CYC clocks, starting at the clock edge of the write.
- R5: The ready flag clears at the edge of the data write. A line is not reported again while its frame is in progress. A data write while the ready flag is clear starts no frame.
- R6: `tx_irq` is 1 exactly when the ready flag and the interrupt-enable bit (status bit 2) are both set.
- R7: If the reported line's mask bit is cleared, the ready flag drops and the scanner goes on to report another enabled idle line.
- R8: Writing 1 to status bit 0 starts a clear lasting CLR_CYCLES clocks. During the clear, bit 0 reads 1 and other register writes are ignored. The clear zeroes the mask and status bits 1 and 2, drops the ready flag and aborts frames so that `txd` returns to 1. Bit 0 reads 0 afterwards.
- R9: No line is reported while the scan-enable bit (status bit 1) is 0.
- R10: After reset or a clear, the search starts at line 0. After line k is served, the search continues at line k+1 and wraps, so the next line reported is the first enabled idle line after k in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| tx_irq | output | 1 | Transmit interrupt |
| txd | output | NLINES | Serial output per line, idle high |

## Verification
The riskiest overlap is a global clear arriving while a frame is being shifted out and the scanner is live. In that cycle the clear must abort the serializer, drop the ready flag and restart the pointer at once. The bench provokes this by loading an all-zero character on a line, so `txd` is visibly low, and issuing the clear mid-frame. It then judges the result at the ports: `txd` must be back high, the status and mask must read zero, and a mask write made during the clear must be lost. A second overlap is a frame completing while the scanner is sweeping. The bench judges it by the line being reported again only after its stop bit.

// File: rtl/txmux_pkg.sv
// Package: shared register addresses and status bit positions for the
// transmit line scanner. Assumes a 2-bit register address space.
package txmux_pkg;
    localparam int unsigned A_STATUS = 0;
    localparam int unsigned A_MASK   = 1;
    localparam int unsigned A_DATA   = 2;

    localparam int unsigned ST_CLR  = 0;   // clear command / in-progress
    localparam int unsigned ST_SCAN = 1;   // master scan enable
    localparam int unsigned ST_TIE  = 2;   // transmit interrupt enable
    localparam int unsigned ST_RDY  = 7;   // transmit ready flag
    localparam int unsigned ST_LINE = 8;   // reported line field base
endpackage

// File: rtl/txmux_ser.sv
// Module: one line serializer. Sends start, 8 data bits LSB first, stop.
// Assumes load is only honoured when idle; abort returns the line to idle.
module txmux_ser #(
    parameter int unsigned BIT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       load,
    input  logic [7:0] data,
    output logic       txd,
    output logic       idle
);
    localparam int unsigned CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(BIT_CYC - 1);

    logic [9:0]    shreg;
    logic [3:0]    bits_left;
    logic [CW-1:0] cnt;
    logic          busy;

    // Purpose: load a frame, then shift one bit every BIT_CYC clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            shreg     <= '1;
            bits_left <= '0;
            cnt       <= '0;
            busy      <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                shreg     <= {1'b1, data, 1'b0};
                bits_left <= 4'd10;
                cnt       <= CNT_TOP;
                busy      <= 1'b1;
            end
        end else if (cnt == '0) begin
            shreg     <= {1'b1, shreg[9:1]};
            bits_left <= bits_left - 4'd1;
            cnt       <= CNT_TOP;
            if (bits_left == 4'd1) begin
                busy <= 1'b0;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Purpose: drive the line; idle level is high.
    always_comb begin
        txd  = busy ? shreg[0] : 1'b1;
        idle = !busy;
    end
endmodule

// File: rtl/txmux_arbiter.sv
// Module: round-robin scanner. Steps one line per clock while searching,
// holds the found line until it is served, disabled or scanning stops.
// Assumes flush is held for the whole clear period.
module txmux_arbiter #(
    parameter int unsigned NLINES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      scan_en,
    input  logic [NLINES-1:0]         mask,
    input  logic [NLINES-1:0]         idle,
    input  logic                      take,
    output logic                      rdy,
    output logic [$clog2(NLINES)-1:0] line
);
    localparam int unsigned LW = $clog2(NLINES);
    localparam logic [LW-1:0] LAST = LW'(NLINES - 1);

    logic [LW-1:0] ptr;
    logic [LW-1:0] ptr_nxt;

    // Purpose: wrap the search pointer after the last line.
    always_comb begin
        ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Purpose: search, hold and release the reported line.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr  <= '0;
            rdy  <= 1'b0;
            line <= '0;
        end else if (rdy) begin
            if (take || !mask[line] || !scan_en) begin
                rdy <= 1'b0;
            end
        end else if (scan_en) begin
            if (mask[ptr] && idle[ptr]) begin
                rdy  <= 1'b1;
                line <= ptr;
            end
            ptr <= ptr_nxt;
        end
    end
endmodule

// File: rtl/txmux_clr.sv
// Module: clear sequencer. A start pulse keeps busy high for CLR_CYCLES
// clocks. Assumes start is ignored by the caller while busy.
module txmux_clr #(
    parameter int unsigned CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CW = $clog2(CLR_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Purpose: count down the clear period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CLR_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Purpose: busy while the count is running.
    always_comb begin
        busy = (cnt != '0);
    end
endmodule

// File: rtl/txmux_scan.sv
// Module: top of the multiplexed transmit scanner. Holds the control
// registers, decodes the register window and ties the scanner, clear
// sequencer and per-line serializers together.
// Assumes NLINES <= 8 so the line field fits in the status word.
module txmux_scan
    import txmux_pkg::*;
#(
    parameter int unsigned NLINES     = 4,
    parameter int unsigned BIT_CYC    = 4,
    parameter int unsigned CLR_CYCLES = 4,
    parameter int unsigned AW         = 2,
    parameter int unsigned DW         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              tx_irq,
    output logic [NLINES-1:0] txd
);
    localparam int unsigned LW = $clog2(NLINES);

    logic [NLINES-1:0] mask_q;
    logic              mse_q;
    logic              tie_q;
    logic              clr_busy;
    logic              clr_start;
    logic              wr_ok;
    logic              take;
    logic              rdy;
    logic [LW-1:0]     rep_line;
    logic [NLINES-1:0] ser_idle;
    logic [NLINES-1:0] load_vec;

    // Purpose: decode register writes; all writes are dropped during a clear.
    always_comb begin
        wr_ok     = reg_wr && !clr_busy;
        clr_start = wr_ok && (reg_addr == AW'(A_STATUS)) && reg_wdata[ST_CLR];
        take      = wr_ok && (reg_addr == AW'(A_DATA)) && rdy;
    end

    // Purpose: hold mask and control bits; a clear command zeroes them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_start) begin
            mask_q <= '0;
            mse_q  <= 1'b0;
            tie_q  <= 1'b0;
        end else if (wr_ok) begin
            if (reg_addr == AW'(A_STATUS)) begin
                mse_q <= reg_wdata[ST_SCAN];
                tie_q <= reg_wdata[ST_TIE];
            end else if (reg_addr == AW'(A_MASK)) begin
                mask_q <= reg_wdata[NLINES-1:0];
            end
        end
    end

    txmux_clr #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clr_start),
        .busy  (clr_busy)
    );

    txmux_arbiter #(.NLINES(NLINES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (clr_busy),
        .scan_en (mse_q),
        .mask    (mask_q),
        .idle    (ser_idle),
        .take    (take),
        .rdy     (rdy),
        .line    (rep_line)
    );

    generate
        for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
            // Purpose: steer the data write to the reported line only.
            always_comb begin
                load_vec[gi] = take && (rep_line == LW'(gi));
            end

            txmux_ser #(.BIT_CYC(BIT_CYC)) u_ser (
                .clk   (clk),
                .rst_n (rst_n),
                .abort (clr_busy),
                .load  (load_vec[gi]),
                .data  (reg_wdata[7:0]),
                .txd   (txd[gi]),
                .idle  (ser_idle[gi])
            );
        end
    endgenerate

    // Purpose: read mux for the register window.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(A_STATUS)) begin
            reg_rdata[ST_CLR]          = clr_busy;
            reg_rdata[ST_SCAN]         = mse_q;
            reg_rdata[ST_TIE]          = tie_q;
            reg_rdata[ST_RDY]          = rdy;
            reg_rdata[ST_LINE +: LW]   = rdy ? rep_line : '0;
        end else if (reg_addr == AW'(A_MASK)) begin
            reg_rdata[NLINES-1:0] = mask_q;
        end
    end

    // Purpose: interrupt request from ready and enable.
    always_comb begin
        tx_irq = rdy && tie_q;
    end
endmodule

// File: rtl/txmux_scan_chk.sv
// Module: assertion checker for txmux_scan, attached by bind below.
// Assumes it sees the top's internal control and scanner signals.
module txmux_scan_chk #(
    parameter int unsigned NLINES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rdy,
    input logic [$clog2(NLINES)-1:0] cur,
    input logic                      take,
    input logic [NLINES-1:0]         mask_q,
    input logic                      mse_q,
    input logic                      clr_busy,
    input logic [NLINES-1:0]         ser_idle,
    input logic [NLINES-1:0]         load_vec,
    input logic                      tx_irq
);
    p_one_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));

    p_take_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !rdy);

    p_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ser_idle[$past(cur)]);

    p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> ser_idle[cur]);

    p_drop_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !mask_q[cur]) |=> !rdy);

    p_clear_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> (mask_q == '0));

    p_clear_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !rdy);

    p_no_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mse_q |=> !rdy);
endmodule

bind txmux_scan txmux_scan_chk #(.NLINES(NLINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy      (rdy),
    .cur      (rep_line),
    .take     (take),
    .mask_q   (mask_q),
    .mse_q    (mse_q),
    .clr_busy (clr_busy),
    .ser_idle (ser_idle),
    .load_vec (load_vec),
    .tx_irq   (tx_irq)
);

// File: tb/txmux_scan_tb.sv
module txmux_scan_tb;
    localparam int NL = 4;
    localparam int BC = 4;
    localparam int CLRC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_irq;
    logic [NL-1:0] txd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txmux_scan #(.NLINES(NL), .BIT_CYC(BC), .CLR_CYCLES(CLRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_irq(tx_irq), .txd(txd)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  addr;
        logic [15:0] data;   // write data or expected read value
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'd0, 16'h0000},   // R1 status after reset
        '{1'b0, 2'd1, 16'h0000},   // R1 mask after reset
        '{1'b0, 2'd2, 16'h0000},   // R1 data reads zero
        '{1'b1, 2'd1, 16'h000A},
        '{1'b0, 2'd1, 16'h000A},   // R2 readback
        '{1'b1, 2'd0, 16'h0004},   // interrupt enable only
        '{1'b0, 2'd0, 16'h0004},   // R9 no ready without scan enable
        '{1'b1, 2'd1, 16'hFFF5},   // upper bits dropped
        '{1'b0, 2'd1, 16'h0005},   // R2 low NLINES bits only
        '{1'b0, 2'd3, 16'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic poll(output bit found, output int ln);
        logic [15:0] s;
        found = 1'b0; ln = -1;
        for (int k = 0; k < 40 && !found; k++) begin
            rd(2'd0, s);
            if (s[7]) begin
                found = 1'b1;
                ln = int'(s[9:8]);
            end
        end
    endtask

    function automatic int next_en(input logic [NL-1:0] m, input int after);
        for (int k = 1; k <= NL; k++) begin
            if (m[(after + k) % NL]) return (after + k) % NL;
        end
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        bit f;
        int ln, l0;
        logic [9:0] frame;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", tx_irq, 0);
        check("R1 txd", txd, 4'hF);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) wr(VT[i].addr, VT[i].data);
            else begin
                rd(VT[i].addr, v);
                check($sformatf("table %0d R1/R2/R9", i), v, VT[i].data);
            end
        end

        // R9: scan disabled, all lines enabled, nothing reported
        wr(2'd1, 16'h000F);
        repeat (20) @(negedge clk);
        rd(2'd0, v);
        check("R9 no ready", v[7], 0);
        check("R6 irq off", tx_irq, 0);

        // R10/R6/R3: start scan, first report is line 0
        wr(2'd0, 16'h0006);
        poll(f, ln);
        check("R3 ready seen", f, 1);
        check("R10 first line", ln, 0);
        check("R6 irq on", tx_irq, 1);
        wr(2'd1, 16'h0001);

        // R4/R5: send 0xA5 on line 0
        wr(2'd2, 16'h00A5);
        rd(2'd0, v);
        check("R5 ready cleared", v[7], 0);
        check("R6 irq follows", tx_irq, 0);
        frame = {1'b1, 8'hA5, 1'b0};
        // rd consumed one negedge: now W+1.5, inside bit 0
        for (int b = 0; b < 10; b++) begin
            check($sformatf("R4 frame bit %0d", b), txd[0], frame[b]);
            if (b == 5) check("R5 busy not reported", reg_rdata[7], 0);
            repeat (BC) @(negedge clk);
        end
        poll(f, ln);
        check("R5 re-reported after stop", f, 1);
        check("R3 line field", ln, 0);

        // R5: write while not ready starts nothing
        wr(2'd1, 16'h0000);
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        check("R7 ready dropped", v[7], 0);
        check("R3 field zero", v[9:8], 0);
        wr(2'd2, 16'h0000);
        repeat (2) @(negedge clk);
        check("R5 ignored write", txd, 4'hF);

        // R10: round robin over all lines
        wr(2'd1, 16'h000F);
        poll(f, l0);
        check("R10 found", f, 1);
        wr(2'd2, 16'h0011);
        for (int k = 1; k < NL; k++) begin
            poll(f, ln);
            check($sformatf("R10 order step %0d", k), ln, (l0 + k) % NL);
            wr(2'd2, 16'h0022);
        end
        repeat (3) @(negedge clk);
        rd(2'd0, v);
        check("R5 all busy none ready", v[7], 0);
        repeat (60) @(negedge clk);

        // R10/R2: skip disabled line 2
        wr(2'd1, 16'h000B);
        poll(f, l0);
        check("R2 disabled never reported", l0 != 2, 1);
        wr(2'd2, 16'h0033);
        poll(f, ln);
        check("R10 skip order", ln, next_en(4'hB, l0));
        wr(2'd2, 16'h0044);
        poll(f, ln);
        check("R10 skip order 2", ln, next_en(4'hB, next_en(4'hB, l0)));
        wr(2'd2, 16'h0055);
        repeat (60) @(negedge clk);

        // R7: drop reported line, other one follows
        wr(2'd1, 16'h0003);
        poll(f, l0);
        wr(2'd1, (l0 == 0) ? 16'h0002 : 16'h0001);
        poll(f, ln);
        check("R7 other line", ln, 1 - l0);

        // R8: clear during an active frame
        wr(2'd1, 16'h0001);
        poll(f, ln);
        wr(2'd2, 16'h0000);
        repeat (6) @(negedge clk);
        check("R4 line low mid-frame", txd[0], 0);
        wr(2'd0, 16'h0001);
        rd(2'd0, v);
        check("R8 clear bit set", v[0], 1);
        wr(2'd1, 16'h000F);
        repeat (CLRC + 2) @(negedge clk);
        rd(2'd0, v);
        check("R8 status zero", v, 16'h0000);
        rd(2'd1, v);
        check("R8 mask zero, write ignored", v, 16'h0000);
        check("R8 frame aborted", txd, 4'hF);
        check("R8 irq off", tx_irq, 0);

        // R10: after clear, search restarts at line 0
        wr(2'd1, 16'h000F);
        wr(2'd0, 16'h0002);
        poll(f, ln);
        check("R10 restart at 0", ln, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule